// File: doc/BRIEF.md
# Nibble Register Array with Byte-Pair View

This block holds a bank of sixteen 4-bit working registers. Each register can be read, loaded from an accumulator value, incremented in place, or exchanged with the accumulator. The register being exchanged hands its previous contents back on the read output so that the caller can move them into its accumulator. None of these operations needs an external memory cycle.

The same storage can also be treated as eight byte-wide pairs. Each pair can serve as an 8-bit address pointer. A pair can be read out whole, or written whole with a single byte in one clock.

One operation code is applied per clock, together with a register index, a pair index and the write values. Every output is registered. Each output keeps its value until an operation that is defined to update it takes place.

Top module: `nibreg_array`

## Requirements
- R1: A synchronous active-high reset clears all sixteen registers to 0x0, and clears `rd_data_o`, `pair_data_o` and `zero_o` to zero.
- R2: With `op_i` = 1 (read), `rd_data_o` shows the contents of register `reg_idx_i` one clock later, and the array is not changed.
- R3: With `op_i` = 2 (load), register `reg_idx_i` takes `acc_i` at the clock edge.
- R4: With `op_i` = 3 (increment), register `reg_idx_i` becomes its old value plus one modulo 16, so 0xF wraps to 0x0. `rd_data_o` shows the new value one clock later.
- R5: `zero_o` is updated only by increment. It goes to 1 when the incremented result is 0x0 and to 0 otherwise, and it holds its value under every other operation.
- R6: With `op_i` = 4 (exchange), register `reg_idx_i` takes `acc_i` and `rd_data_o` shows the value the register held before the edge. Both happen in the same clock.
- R7: Pair p (index 0..7) is formed from register 2p as bits [7:4] and register 2p+1 as bits [3:0]. With `op_i` = 5 (pair read), `pair_data_o` shows pair `pair_idx_i` one clock later.
- R8: With `op_i` = 6 (pair load), register 2p takes `pair_wdata_i[7:4]` and register 2p+1 takes `pair_wdata_i[3:0]`, both in the same clock edge, where p = `pair_idx_i`.
- R9: `op_i` = 0 (no operation) and `op_i` = 7 (reserved) change neither the array nor any output.
- R10: `rd_data_o` changes only on read, increment or exchange. `pair_data_o` changes only on pair read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 3 | Operation code: 0 none, 1 read, 2 load, 3 increment, 4 exchange, 5 pair read, 6 pair load, 7 reserved |
| reg_idx_i | input | 4 | Register index for single-register operations |
| pair_idx_i | input | 3 | Pair index for pair operations |
| acc_i | input | 4 | Accumulator value for load and exchange |
| pair_wdata_i | input | 8 | Byte written by pair load |
| rd_data_o | output | 4 | Registered register value |
| pair_data_o | output | 8 | Registered pair value |
| zero_o | output | 1 | Registered zero flag from the last increment |

## Verification
Every output is registered, so any write into the array stays hidden until a later read or pair read brings it out one clock later. A nibble written to the wrong register, or a pair built with its halves swapped, therefore shows up on the first read of the affected register or pair that follows. The stimulus reads back both neighbours of each pair it writes and mixes nibble and pair accesses to the same storage. This exposes a misplaced write within two clocks of the write. Holding behaviour is checked by applying operations that must not update an output and then comparing that output with its earlier value on the next sample.

// File: rtl/nibreg_pkg.sv
package nibreg_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_READ  = 3'd1,
    OP_LOAD  = 3'd2,
    OP_INC   = 3'd3,
    OP_XCH   = 3'd4,
    OP_PREAD = 3'd5,
    OP_PLOAD = 3'd6,
    OP_RSVD  = 3'd7
  } nib_op_e;

  typedef struct packed {
    logic nib_we;    // write one nibble
    logic use_inc;   // nibble write / read-out takes the incremented value
    logic pair_we;   // write a whole pair
    logic rd_upd;    // refresh rd_data_o
    logic pair_upd;  // refresh pair_data_o
    logic zero_upd;  // refresh zero_o
  } nib_ctrl_t;

endpackage

// File: rtl/nibreg_decode.sv
module nibreg_decode
  import nibreg_pkg::*;
(
  input  logic [2:0] op,
  output nib_ctrl_t  ctrl
);

  nib_op_e op_e;
  assign op_e = nib_op_e'(op);

  always_comb begin
    ctrl = '0;
    unique case (op_e)
      OP_READ:  ctrl.rd_upd = 1'b1;
      OP_LOAD:  ctrl.nib_we = 1'b1;
      OP_INC: begin
        ctrl.nib_we   = 1'b1;
        ctrl.use_inc  = 1'b1;
        ctrl.rd_upd   = 1'b1;
        ctrl.zero_upd = 1'b1;
      end
      OP_XCH: begin
        ctrl.nib_we = 1'b1;
        ctrl.rd_upd = 1'b1;
      end
      OP_PREAD: ctrl.pair_upd = 1'b1;
      OP_PLOAD: ctrl.pair_we  = 1'b1;
      default:  ctrl = '0;
    endcase
  end

endmodule

// File: rtl/nibreg_incr.sv
module nibreg_incr #(
  parameter int NIB_W = 4
) (
  input  logic [NIB_W-1:0] din,
  output logic [NIB_W-1:0] dout,
  output logic             is_zero
);

  assign dout    = din + NIB_W'(1);
  assign is_zero = (dout == '0);

endmodule

// File: rtl/nibreg_store.sv
module nibreg_store #(
  parameter int NIB_W    = 4,
  parameter int NUM_REGS = 16,
  localparam int PAIR_W    = 2 * NIB_W,
  localparam int NUM_PAIRS = NUM_REGS / 2,
  localparam int IDX_W     = $clog2(NUM_REGS),
  localparam int PIDX_W    = $clog2(NUM_PAIRS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nib_we,
  input  logic [IDX_W-1:0]  nib_widx,
  input  logic [NIB_W-1:0]  nib_wdata,
  input  logic              pair_we,
  input  logic [PIDX_W-1:0] pair_widx,
  input  logic [PAIR_W-1:0] pair_wdata,
  input  logic [IDX_W-1:0]  nib_ridx,
  output logic [NIB_W-1:0]  nib_rdata,
  input  logic [PIDX_W-1:0] pair_ridx,
  output logic [PAIR_W-1:0] pair_rdata
);

  logic [NUM_PAIRS-1:0][PAIR_W-1:0] pair_view;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic [NIB_W-1:0] hi_q, lo_q;
    logic pair_hit, hi_hit, lo_hit;

    assign pair_hit = pair_we && (pair_widx == PIDX_W'(p));
    assign hi_hit   = nib_we && (nib_widx == IDX_W'(2 * p));
    assign lo_hit   = nib_we && (nib_widx == IDX_W'(2 * p + 1));

    always_ff @(posedge clk) begin
      if (rst) begin
        hi_q <= '0;
        lo_q <= '0;
      end else if (pair_hit) begin
        hi_q <= pair_wdata[PAIR_W-1:NIB_W];
        lo_q <= pair_wdata[NIB_W-1:0];
      end else begin
        if (hi_hit) hi_q <= nib_wdata;
        if (lo_hit) lo_q <= nib_wdata;
      end
    end

    assign pair_view[p] = {hi_q, lo_q};
  end

  logic [PAIR_W-1:0] nib_pair_sel;
  assign nib_pair_sel = pair_view[nib_ridx[IDX_W-1:1]];
  assign nib_rdata    = nib_ridx[0] ? nib_pair_sel[NIB_W-1:0]
                                    : nib_pair_sel[PAIR_W-1:NIB_W];
  assign pair_rdata   = pair_view[pair_ridx];

endmodule

// File: rtl/nibreg_array.sv
module nibreg_array
  import nibreg_pkg::*;
#(
  parameter int NIB_W    = 4,
  parameter int NUM_REGS = 16,
  localparam int PAIR_W    = 2 * NIB_W,
  localparam int NUM_PAIRS = NUM_REGS / 2,
  localparam int IDX_W     = $clog2(NUM_REGS),
  localparam int PIDX_W    = $clog2(NUM_PAIRS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [PIDX_W-1:0] pair_idx_i,
  input  logic [NIB_W-1:0]  acc_i,
  input  logic [PAIR_W-1:0] pair_wdata_i,
  output logic [NIB_W-1:0]  rd_data_o,
  output logic [PAIR_W-1:0] pair_data_o,
  output logic              zero_o
);

  nib_ctrl_t         ctrl;
  logic [NIB_W-1:0]  cur_nib, inc_nib, wr_nib;
  logic [PAIR_W-1:0] cur_pair;
  logic              inc_zero;

  nibreg_decode u_decode (
    .op   (op_i),
    .ctrl (ctrl)
  );

  nibreg_incr #(.NIB_W(NIB_W)) u_incr (
    .din     (cur_nib),
    .dout    (inc_nib),
    .is_zero (inc_zero)
  );

  assign wr_nib = ctrl.use_inc ? inc_nib : acc_i;

  nibreg_store #(.NIB_W(NIB_W), .NUM_REGS(NUM_REGS)) u_store (
    .clk        (clk),
    .rst        (rst),
    .nib_we     (ctrl.nib_we),
    .nib_widx   (reg_idx_i),
    .nib_wdata  (wr_nib),
    .pair_we    (ctrl.pair_we),
    .pair_widx  (pair_idx_i),
    .pair_wdata (pair_wdata_i),
    .nib_ridx   (reg_idx_i),
    .nib_rdata  (cur_nib),
    .pair_ridx  (pair_idx_i),
    .pair_rdata (cur_pair)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o   <= '0;
      pair_data_o <= '0;
      zero_o      <= 1'b0;
    end else begin
      if (ctrl.rd_upd)   rd_data_o   <= ctrl.use_inc ? inc_nib : cur_nib;
      if (ctrl.pair_upd) pair_data_o <= cur_pair;
      if (ctrl.zero_upd) zero_o      <= inc_zero;
    end
  end

endmodule

// File: rtl/nibreg_array_chk.sv
module nibreg_array_chk
  import nibreg_pkg::*;
#(
  parameter int NIB_W    = 4,
  parameter int NUM_REGS = 16,
  localparam int PAIR_W    = 2 * NIB_W,
  localparam int NUM_PAIRS = NUM_REGS / 2,
  localparam int IDX_W     = $clog2(NUM_REGS),
  localparam int PIDX_W    = $clog2(NUM_PAIRS)
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        op_i,
  input logic [IDX_W-1:0]  reg_idx_i,
  input logic [PIDX_W-1:0] pair_idx_i,
  input logic [NIB_W-1:0]  acc_i,
  input logic [PAIR_W-1:0] pair_wdata_i,
  input logic [NIB_W-1:0]  rd_data_o,
  input logic [PAIR_W-1:0] pair_data_o,
  input logic              zero_o
);

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst_d && !rst |-> (rd_data_o == '0 && pair_data_o == '0 && !zero_o)); // R1

  AST_ZERO_MATCHES_INC: assert property (@(posedge clk) disable iff (rst)
    op_i == OP_INC |=> zero_o == (rd_data_o == '0)); // R5

  AST_ZERO_HELD: assert property (@(posedge clk) disable iff (rst)
    op_i != OP_INC |=> $stable(zero_o)); // R5

  AST_RD_HELD: assert property (@(posedge clk) disable iff (rst)
    !(op_i inside {OP_READ, OP_INC, OP_XCH}) |=> $stable(rd_data_o)); // R10

  AST_PAIR_HELD: assert property (@(posedge clk) disable iff (rst)
    op_i != OP_PREAD |=> $stable(pair_data_o)); // R10

  AST_XCH_STORES_ACC: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_XCH ##1 (op_i == OP_READ && reg_idx_i == $past(reg_idx_i)))
    |=> rd_data_o == $past(acc_i, 2)); // R6

  AST_LOAD_STORES_ACC: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_LOAD ##1 (op_i == OP_READ && reg_idx_i == $past(reg_idx_i)))
    |=> rd_data_o == $past(acc_i, 2)); // R3

  AST_PLOAD_STORES_BYTE: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_PLOAD ##1 (op_i == OP_PREAD && pair_idx_i == $past(pair_idx_i)))
    |=> pair_data_o == $past(pair_wdata_i, 2)); // R8

endmodule

bind nibreg_array nibreg_array_chk #(.NIB_W(NIB_W), .NUM_REGS(NUM_REGS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .op_i         (op_i),
  .reg_idx_i    (reg_idx_i),
  .pair_idx_i   (pair_idx_i),
  .acc_i        (acc_i),
  .pair_wdata_i (pair_wdata_i),
  .rd_data_o    (rd_data_o),
  .pair_data_o  (pair_data_o),
  .zero_o       (zero_o)
);

// File: tb/nibreg_array_tb.sv
module nibreg_array_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] op_i = '0;
  logic [3:0] reg_idx_i = '0;
  logic [2:0] pair_idx_i = '0;
  logic [3:0] acc_i = '0;
  logic [7:0] pair_wdata_i = '0;
  logic [3:0] rd_data_o;
  logic [7:0] pair_data_o;
  logic       zero_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  nibreg_array u_dut (
    .clk          (clk),
    .rst          (rst),
    .op_i         (op_i),
    .reg_idx_i    (reg_idx_i),
    .pair_idx_i   (pair_idx_i),
    .acc_i        (acc_i),
    .pair_wdata_i (pair_wdata_i),
    .rd_data_o    (rd_data_o),
    .pair_data_o  (pair_data_o),
    .zero_o       (zero_o)
  );

  // {req, op, reg idx, pair idx, acc, byte, exp rd, exp pair, exp zero}
  // op codes: 0 none, 1 read, 2 load, 3 inc, 4 xch, 5 pair read, 6 pair load, 7 reserved
  localparam int NVEC = 23;
  localparam logic [38:0] VEC [NVEC] = '{
    {4'd3,  3'd2, 4'd5,  3'd0, 4'hA, 8'h00, 4'h0, 8'h00, 1'b0}, // R3 load r5
    {4'd2,  3'd1, 4'd5,  3'd0, 4'h0, 8'h00, 4'hA, 8'h00, 1'b0}, // R2 read r5
    {4'd4,  3'd3, 4'd5,  3'd0, 4'h0, 8'h00, 4'hB, 8'h00, 1'b0}, // R4 inc r5
    {4'd6,  3'd4, 4'd5,  3'd0, 4'h3, 8'h00, 4'hB, 8'h00, 1'b0}, // R6 xch r5 returns old
    {4'd6,  3'd1, 4'd5,  3'd0, 4'h0, 8'h00, 4'h3, 8'h00, 1'b0}, // R6 r5 took acc
    {4'd10, 3'd2, 4'd4,  3'd0, 4'h7, 8'h00, 4'h3, 8'h00, 1'b0}, // R10 load holds rd
    {4'd7,  3'd5, 4'd0,  3'd2, 4'h0, 8'h00, 4'h3, 8'h73, 1'b0}, // R7 pair2 = r4:r5
    {4'd10, 3'd6, 4'd0,  3'd7, 4'h0, 8'hFF, 4'h3, 8'h73, 1'b0}, // R10 pair load holds outputs
    {4'd5,  3'd3, 4'd14, 3'd0, 4'h0, 8'h00, 4'h0, 8'h73, 1'b1}, // R5 F wraps to 0, flag set
    {4'd8,  3'd1, 4'd15, 3'd0, 4'h0, 8'h00, 4'hF, 8'h73, 1'b1}, // R8 low half of pair7
    {4'd8,  3'd5, 4'd0,  3'd7, 4'h0, 8'h00, 4'hF, 8'h0F, 1'b1}, // R8 pair7 after inc
    {4'd4,  3'd3, 4'd15, 3'd0, 4'h0, 8'h00, 4'h0, 8'h0F, 1'b1}, // R4 wrap
    {4'd5,  3'd3, 4'd15, 3'd0, 4'h0, 8'h00, 4'h1, 8'h0F, 1'b0}, // R5 flag clears
    {4'd9,  3'd0, 4'd1,  3'd0, 4'h9, 8'hAA, 4'h1, 8'h0F, 1'b0}, // R9 no-op
    {4'd9,  3'd7, 4'd0,  3'd0, 4'h5, 8'hAA, 4'h1, 8'h0F, 1'b0}, // R9 reserved code
    {4'd9,  3'd1, 4'd0,  3'd0, 4'h0, 8'h00, 4'h0, 8'h0F, 1'b0}, // R9 r0 untouched
    {4'd9,  3'd5, 4'd0,  3'd0, 4'h0, 8'h00, 4'h0, 8'h00, 1'b0}, // R9 pair0 untouched
    {4'd8,  3'd6, 4'd0,  3'd0, 4'h0, 8'h5C, 4'h0, 8'h00, 1'b0}, // R8 pair load pair0
    {4'd7,  3'd1, 4'd0,  3'd0, 4'h0, 8'h00, 4'h5, 8'h00, 1'b0}, // R7 high nibble in r0
    {4'd7,  3'd1, 4'd1,  3'd0, 4'h0, 8'h00, 4'hC, 8'h00, 1'b0}, // R7 low nibble in r1
    {4'd7,  3'd5, 4'd0,  3'd0, 4'h0, 8'h00, 4'hC, 8'h5C, 1'b0}, // R7 pair0 read
    {4'd6,  3'd4, 4'd1,  3'd0, 4'h0, 8'h00, 4'hC, 8'h5C, 1'b0}, // R6 xch r1 with 0
    {4'd6,  3'd5, 4'd0,  3'd0, 4'h0, 8'h00, 4'hC, 8'h50, 1'b0}  // R6 seen via pair view
  };

  task automatic check(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic [3:0] ri, input logic [2:0] pi,
                      input logic [3:0] acc, input logic [7:0] byt);
    op_i = op; reg_idx_i = ri; pair_idx_i = pi; acc_i = acc; pair_wdata_i = byt;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: outputs cleared out of reset
    check(1, "rd after reset", 32'(rd_data_o), 32'h0);
    check(1, "pair after reset", 32'(pair_data_o), 32'h0);
    check(1, "zero after reset", 32'(zero_o), 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      logic [38:0] v;
      v = VEC[i];
      step(v[34:32], v[31:28], v[27:25], v[24:21], v[20:13]);
      check(int'(v[38:35]), $sformatf("vec%0d rd", i), 32'(rd_data_o), 32'(v[12:9]));
      check(int'(v[38:35]), $sformatf("vec%0d pair", i), 32'(pair_data_o), 32'(v[8:1]));
      check(int'(v[38:35]), $sformatf("vec%0d zero", i), 32'(zero_o), 32'(v[0]));
    end

    // R1: reset in the middle of a run, even with an increment pending
    step(3'd3, 4'd15, 3'd0, 4'h0, 8'h00);
    rst = 1'b1;
    step(3'd3, 4'd2, 3'd0, 4'h0, 8'h00);
    step(3'd3, 4'd2, 3'd0, 4'h0, 8'h00);
    op_i = 3'd0;
    rst = 1'b0;
    check(1, "rd after mid reset", 32'(rd_data_o), 32'h0);
    check(1, "pair after mid reset", 32'(pair_data_o), 32'h0);
    check(1, "zero after mid reset", 32'(zero_o), 32'h0);
    for (int r = 0; r < 16; r++) begin
      step(3'd1, 4'(r), 3'd0, 4'h0, 8'h00);
      check(1, $sformatf("r%0d cleared", r), 32'(rd_data_o), 32'h0);
    end
    for (int p = 0; p < 8; p++) begin
      step(3'd5, 4'd0, 3'(p), 4'h0, 8'h00);
      check(1, $sformatf("pair%0d cleared", p), 32'(pair_data_o), 32'h0);
    end

    // R8: pair load on every pair, then both halves read singly
    for (int p = 0; p < 8; p++) begin
      step(3'd6, 4'd0, 3'(p), 4'h0, 8'(8'h10 * (p + 1) + (7 - p)));
    end
    for (int p = 0; p < 8; p++) begin
      step(3'd1, 4'(2 * p), 3'd0, 4'h0, 8'h00);
      check(8, $sformatf("pair%0d high half", p), 32'(rd_data_o), 32'((p + 1) & 15));
      step(3'd1, 4'(2 * p + 1), 3'd0, 4'h0, 8'h00);
      check(8, $sformatf("pair%0d low half", p), 32'(rd_data_o), 32'(7 - p));
    end

    // R4: sixteen increments of one register return it to its start value
    step(3'd2, 4'd9, 3'd0, 4'h6, 8'h00);
    for (int k = 1; k <= 16; k++) begin
      step(3'd3, 4'd9, 3'd0, 4'h0, 8'h00);
      check(4, $sformatf("inc #%0d", k), 32'(rd_data_o), 32'((6 + k) & 15));
      check(5, $sformatf("zero #%0d", k), 32'(zero_o), 32'(((6 + k) & 15) == 0));
    end

    finish_run();
  end

endmodule